// File: doc/BRIEF.md
# External Memory Bus Controller

This block turns single read and write requests from the chip's internal fabric into cycles on an external memory bus. A request carries an address, byte enables and write data. The requester holds it until a one-clock acknowledge comes back. Read data is returned together with that acknowledge.

The shape of each bus cycle is taken from configuration inputs, which are latched when the request is accepted, so every access can use its own settings. The settings are:
- Addressing is either multiplexed, where the low address bits travel on the data lines while ALE is high, or demultiplexed.
- ALE can be one clock long or extended to two.
- The command strobe can be delayed by one clock.
- From 0 up to 2^WAIT_W-1 wait clocks can be added.
- A READY handshake can be used, sampled either directly or through a two-flop synchronizer.

One address window, given as a base and a mask, drives the chip select and the read and write chip-select strobes.

An external master can take the bus with an active-low hold request. The controller completes any cycle in progress, then grants the bus and turns off every output enable. While the bus is released, a pending internal request raises a bus-request output, so that the external master can give the bus back.

Top module: `extBusCtrl`

## Requirements
- R1: After reset, ALE is low and the read strobe, both write lane strobes, chip select, byte-high enable, hold acknowledge and bus request are all high (inactive). The control outputs are enabled and reqAck is low.
- R2: A multiplexed cycle lasts 6 clocks from the first ALE clock to the acknowledge clock, both included, when ALE is normal, there is no delay, there are no waits and READY is not used. The clocks are 1 ALE clock, 1 address-hold clock, 3 command clocks and 1 tail clock. During ALE the data lines are driven with the low address bits.
- R3: A demultiplexed cycle lasts 4 clocks: 1 ALE clock, 2 command clocks and 1 tail clock. During a read cycle the data lines are never driven.
- R4: When read/write delay is selected, the command strobe starts one clock later and is one clock shorter. The total cycle length does not change.
- R5: Extended ALE keeps ALE high for 2 clocks and adds one clock to the cycle.
- R6: Each wait state adds one clock to the command phase.
- R7: With synchronous READY, busReadyN is sampled at the clock edge that ends the last programmed command clock. Each sample that finds it high adds one command clock. When READY is disabled, busReadyN has no effect.
- R8: With asynchronous READY, the level passes through two flops and one extra command clock is always added. The command phase ends at the first edge at which the synchronized level shows ready.
- R9: busCsN is low for the whole cycle only when (address AND csMask) equals csBase. busRdCsN and busWrCsN are low exactly when the command strobe is low and the address is in the window. They stay high outside the window.
- R10: On a write, busWrN[i] is low only for the lanes whose reqBe[i] is 1, with lane 0 being the low byte. busBheN is low during the cycle when reqBe[1] is 1. The write data is driven on the data lines during the command phase.
- R11: Read data is captured at the edge that ends the command phase and is presented on rspRdata while reqAck is high. reqAck is high for exactly one clock.
- R12: When busHoldN is low, the cycle in progress completes at its full length. Hold acknowledge then goes low, all output enables go low and busCsN stays high.
- R13: While the bus is released, a pending request drives busBreqN low. When busHoldN returns high the controller takes the bus back and runs the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus phase per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMux | input | 1 | 1 = multiplexed address/data |
| cfgExtAle | input | 1 | 1 = two-clock ALE |
| cfgRwDelay | input | 1 | 1 = delay the command strobe by one clock |
| cfgWait | input | WAIT_W | Wait clocks added to the command phase |
| cfgReadyEn | input | 1 | 1 = use READY handshake |
| cfgReadyAsync | input | 1 | 1 = READY goes through the synchronizer |
| csBase | input | ADDR_W | Chip-select window base |
| csMask | input | ADDR_W | Chip-select window compare mask |
| reqValid | input | 1 | Request pending, held until reqAck |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqBe | input | BE_W | Byte enables, bit 0 = low byte |
| reqWdata | input | DATA_W | Write data |
| reqAck | output | 1 | One-clock completion pulse |
| rspRdata | output | DATA_W | Read data, valid with reqAck |
| busAle | output | 1 | Address latch enable |
| busRdN | output | 1 | Read strobe, active low |
| busWrN | output | BE_W | Per-lane write strobes, active low |
| busBheN | output | 1 | Byte-high enable, active low |
| busCsN | output | 1 | Chip select, active low |
| busRdCsN | output | 1 | Read chip-select strobe, active low |
| busWrCsN | output | 1 | Write chip-select strobe, active low |
| busAddr | output | ADDR_W | Address lines |
| busAddrOe | output | 1 | Address line output enable |
| busDataOut | output | DATA_W | Data lines out (address in multiplexed ALE) |
| busDataOe | output | 1 | Data line output enable |
| busDataIn | input | DATA_W | Data lines in |
| busCtrlOe | output | 1 | Output enable for strobes and selects |
| busReadyN | input | 1 | READY, active low |
| busHoldN | input | 1 | External hold request, active low |
| busHldaN | output | 1 | Hold acknowledge, active low |
| busBreqN | output | 1 | Bus request during release, active low |

## Verification
If the phase counter or state is corrupted, the cycle length changes at once. The effect shows in the number of clocks from the first ALE to the acknowledge, and in the number of command-strobe clocks, so every access measures both and compares them with the values computed from the settings. A wrong latched request shows within the same cycle: the chip select, the lane strobes, the address on the data lines or the returned data do not match the inputs. Errors in the arbitration state show within two clocks after the acknowledge, as a hold acknowledge that comes too early or is missing, an output enable that stays on, or a bus request that does not appear.

// File: rtl/ebcPkg.sv
package ebcPkg;
  localparam int MUX_CMD_PHASES   = 3;
  localparam int DEMUX_CMD_PHASES = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ALE, ST_AHOLD, ST_CMD, ST_RDY, ST_TAIL, ST_HELD
  } ebcState_e;

  typedef struct packed {
    logic load;        // latch the request
    logic addrOnData;  // drive address on data lines
    logic cmd;         // command strobe window
    logic drvWdata;    // write data window
    logic capture;     // capture read data
    logic cycle;       // bus cycle in progress
    logic released;    // bus handed to external master
  } ebcStrobe_t;
endpackage

// File: rtl/ebcCtrl.sv
module ebcCtrl
  import ebcPkg::*;
#(
  parameter int WAIT_W = 4,
  localparam int CNT_W = WAIT_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              cfgMux,
  input  logic              cfgExtAle,
  input  logic              cfgRwDelay,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              cfgReadyEn,
  input  logic              cfgReadyAsync,
  input  logic              busReadyN,
  input  logic              busHoldN,
  output ebcStrobe_t        strobe,
  output logic              reqAck,
  output logic              busAle,
  output logic              busHldaN,
  output logic              busBreqN
);
  ebcState_e state;
  logic [CNT_W-1:0] cnt, cmdLenQ, cmdLenIn;
  logic muxQ, delayQ, rdyEnQ, asyncQ;
  logic [1:0] rdySync;
  logic cmdDone, leaveCmd, firstCmd;

  assign cmdLenIn = CNT_W'(cfgMux ? MUX_CMD_PHASES : DEMUX_CMD_PHASES) + CNT_W'(cfgWait);
  assign cmdDone  = (state == ST_CMD) && (cnt == '0);
  assign leaveCmd = (cmdDone && (!rdyEnQ || (!asyncQ && !busReadyN)))
                 || ((state == ST_RDY) && rdySync[1]);
  assign firstCmd = (state == ST_CMD) && (cnt == cmdLenQ - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      cmdLenQ <= CNT_W'(DEMUX_CMD_PHASES);
      muxQ    <= 1'b0;
      delayQ  <= 1'b0;
      rdyEnQ  <= 1'b0;
      asyncQ  <= 1'b0;
      rdySync <= '0;
    end else begin
      rdySync <= {rdySync[0], !busReadyN};
      case (state)
        ST_IDLE: begin
          if (!busHoldN) begin
            state <= ST_HELD;
          end else if (reqValid) begin
            state   <= ST_ALE;
            cnt     <= CNT_W'(cfgExtAle);
            cmdLenQ <= cmdLenIn;
            muxQ    <= cfgMux;
            delayQ  <= cfgRwDelay;
            rdyEnQ  <= cfgReadyEn;
            asyncQ  <= cfgReadyAsync;
          end
        end
        ST_ALE: begin
          if (cnt == '0) begin
            state <= muxQ ? ST_AHOLD : ST_CMD;
            cnt   <= cmdLenQ - CNT_W'(1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_AHOLD: state <= ST_CMD;
        ST_CMD: begin
          if (cnt != '0)   cnt <= cnt - CNT_W'(1);
          else if (leaveCmd) state <= ST_TAIL;
          else if (rdyEnQ && asyncQ) state <= ST_RDY;
        end
        ST_RDY:  if (rdySync[1]) state <= ST_TAIL;
        ST_TAIL: state <= ST_IDLE;
        ST_HELD: if (busHoldN) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load       = (state == ST_IDLE) && busHoldN && reqValid;
    strobe.addrOnData = (state == ST_ALE) && muxQ;
    strobe.cmd        = ((state == ST_CMD) && !(delayQ && firstCmd)) || (state == ST_RDY);
    strobe.drvWdata   = (state == ST_CMD) || (state == ST_RDY) || (state == ST_TAIL);
    strobe.capture    = leaveCmd;
    strobe.cycle      = (state != ST_IDLE) && (state != ST_HELD);
    strobe.released   = (state == ST_HELD);
  end

  assign reqAck   = (state == ST_TAIL);
  assign busAle   = (state == ST_ALE);
  assign busHldaN = (state != ST_HELD);
  assign busBreqN = !((state == ST_HELD) && reqValid);
endmodule

// File: rtl/ebcDatapath.sv
module ebcDatapath
  import ebcPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ebcStrobe_t        strobe,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BE_W-1:0]   reqBe,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [ADDR_W-1:0] csBase,
  input  logic [ADDR_W-1:0] csMask,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] rspRdata,
  output logic              busRdN,
  output logic [BE_W-1:0]   busWrN,
  output logic              busBheN,
  output logic              busCsN,
  output logic              busRdCsN,
  output logic              busWrCsN,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busAddrOe,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              busCtrlOe
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [BE_W-1:0]   beQ;
  logic              writeQ, hitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      beQ      <= '0;
      writeQ   <= 1'b0;
      hitQ     <= 1'b0;
      rspRdata <= '0;
    end else begin
      if (strobe.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        beQ    <= reqBe;
        writeQ <= reqWrite;
        hitQ   <= ((reqAddr & csMask) == csBase);
      end
      if (strobe.capture && !writeQ) rspRdata <= busDataIn;
    end
  end

  for (genvar lane = 0; lane < BE_W; lane++) begin : gLane
    assign busWrN[lane] = !(strobe.cmd && writeQ && beQ[lane]);
  end

  assign busRdN     = !(strobe.cmd && !writeQ);
  assign busBheN    = !(strobe.cycle && beQ[BE_W-1]);
  assign busCsN     = !(strobe.cycle && hitQ);
  assign busRdCsN   = !(strobe.cmd && !writeQ && hitQ);
  assign busWrCsN   = !(strobe.cmd && writeQ && hitQ);
  assign busAddr    = addrQ;
  assign busAddrOe  = !strobe.released;
  assign busCtrlOe  = !strobe.released;
  assign busDataOut = strobe.addrOnData ? addrQ[DATA_W-1:0] : wdataQ;
  assign busDataOe  = strobe.addrOnData || (writeQ && strobe.drvWdata);
endmodule

// File: rtl/extBusCtrl.sv
module extBusCtrl
  import ebcPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4,
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgMux,
  input  logic              cfgExtAle,
  input  logic              cfgRwDelay,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              cfgReadyEn,
  input  logic              cfgReadyAsync,
  input  logic [ADDR_W-1:0] csBase,
  input  logic [ADDR_W-1:0] csMask,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BE_W-1:0]   reqBe,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqAck,
  output logic [DATA_W-1:0] rspRdata,
  output logic              busAle,
  output logic              busRdN,
  output logic [BE_W-1:0]   busWrN,
  output logic              busBheN,
  output logic              busCsN,
  output logic              busRdCsN,
  output logic              busWrCsN,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busAddrOe,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              busCtrlOe,
  input  logic              busReadyN,
  input  logic              busHoldN,
  output logic              busHldaN,
  output logic              busBreqN
);
  ebcStrobe_t strobe;

  ebcCtrl #(.WAIT_W(WAIT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .cfgMux(cfgMux), .cfgExtAle(cfgExtAle), .cfgRwDelay(cfgRwDelay),
    .cfgWait(cfgWait), .cfgReadyEn(cfgReadyEn), .cfgReadyAsync(cfgReadyAsync),
    .busReadyN(busReadyN), .busHoldN(busHoldN), .strobe(strobe),
    .reqAck(reqAck), .busAle(busAle), .busHldaN(busHldaN), .busBreqN(busBreqN)
  );

  ebcDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqBe(reqBe), .reqWdata(reqWdata),
    .csBase(csBase), .csMask(csMask), .busDataIn(busDataIn),
    .rspRdata(rspRdata), .busRdN(busRdN), .busWrN(busWrN), .busBheN(busBheN),
    .busCsN(busCsN), .busRdCsN(busRdCsN), .busWrCsN(busWrCsN),
    .busAddr(busAddr), .busAddrOe(busAddrOe), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .busCtrlOe(busCtrlOe)
  );
endmodule

// File: rtl/ebcChecker.sv
module ebcChecker #(
  parameter int BE_W = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqAck,
  input logic            busAle,
  input logic            busRdN,
  input logic [BE_W-1:0] busWrN,
  input logic            busCsN,
  input logic            busRdCsN,
  input logic            busWrCsN,
  input logic            busAddrOe,
  input logic            busDataOe,
  input logic            busCtrlOe,
  input logic            busHldaN,
  input logic            busBreqN
);
  assert_release_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !busHldaN |-> (busCsN && !busCtrlOe && !busDataOe && !busAddrOe));

  assert_grant_after_cycle_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busHldaN) |-> ($past(busCsN) && $past(busRdN) && (&$past(busWrN)) && !$past(reqAck)));

  assert_breq_released_R13: assert property (@(posedge clk) disable iff (!rstN)
    !busBreqN |-> !busHldaN);

  assert_rdcs_aligned_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busRdCsN |-> (!busRdN && !busCsN));

  assert_wrcs_aligned_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busWrCsN |-> (busRdN && !busCsN));

  assert_ale_no_cmd_R2: assert property (@(posedge clk) disable iff (!rstN)
    busAle |-> (busRdN && (&busWrN)));

  assert_ack_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);
endmodule

bind extBusCtrl ebcChecker #(.BE_W(BE_W)) uChk (
  .clk(clk), .rstN(rstN), .reqAck(reqAck), .busAle(busAle), .busRdN(busRdN),
  .busWrN(busWrN), .busCsN(busCsN), .busRdCsN(busRdCsN), .busWrCsN(busWrCsN),
  .busAddrOe(busAddrOe), .busDataOe(busDataOe), .busCtrlOe(busCtrlOe),
  .busHldaN(busHldaN), .busBreqN(busBreqN)
);

// File: tb/extBusCtrl_test.sv
`timescale 1ns/1ps
module extBusCtrl_test;
  localparam int ADDR_W = 24, DATA_W = 16, WAIT_W = 4, BE_W = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgMux = 0, cfgExtAle = 0, cfgRwDelay = 0, cfgReadyEn = 0, cfgReadyAsync = 0;
  logic [WAIT_W-1:0] cfgWait = '0;
  logic [ADDR_W-1:0] csBase = 24'h100000, csMask = 24'hF00000;
  logic reqValid = 0, reqWrite = 0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [BE_W-1:0] reqBe = '0;
  logic [DATA_W-1:0] reqWdata = '0, busDataIn = 16'hA5C3;
  logic busReadyN = 0, busHoldN = 1;
  logic reqAck, busAle, busRdN, busBheN, busCsN, busRdCsN, busWrCsN;
  logic busAddrOe, busDataOe, busCtrlOe, busHldaN, busBreqN;
  logic [BE_W-1:0] busWrN;
  logic [DATA_W-1:0] rspRdata, busDataOut;
  logic [ADDR_W-1:0] busAddr;

  int checks = 0, fails = 0;
  bit done = 0;
  int mLen, mAle, mCmd, mCs, mRdCs, mWrCs, mHlda;
  logic [BE_W-1:0] mLane;
  logic mBheN, mAleOe, mCmdOe, mDataOeRd;
  logic [DATA_W-1:0] mAleData, mCmdData, mRdata;

  always #2.5 clk = ~clk;

  extBusCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) uut (.*);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkEq(input string tag, input longint act, input longint exp);
    check(act == exp, tag, act, exp);
  endtask

  function automatic int preLen();
    return 1 + int'(cfgExtAle) + int'(cfgMux);
  endfunction

  // clock index whose edge ends the command phase
  function automatic int endIdx(input int m);
    int nb = preLen() + (cfgMux ? 3 : 2) + int'(cfgWait);
    if (!cfgReadyEn) return nb;
    if (!cfgReadyAsync) return (m > nb) ? m : nb;
    return (m + 2 > nb + 1) ? m + 2 : nb + 1;
  endfunction

  function automatic int expLen(input int m);
    return endIdx(m) + 1;
  endfunction

  function automatic int expCmd(input int m);
    return endIdx(m) - preLen() - int'(cfgRwDelay);
  endfunction

  // m: number of clock indexes during which busReadyN is held high
  task automatic doAccess(input bit wr, input logic [ADDR_W-1:0] a,
                          input logic [BE_W-1:0] be, input logic [DATA_W-1:0] wd, input int m);
    int n = 0;
    bit got = 0;
    mAle = 0; mCmd = 0; mCs = 0; mRdCs = 0; mWrCs = 0; mHlda = 0;
    mLane = '0; mBheN = 1; mAleOe = 0; mCmdOe = 0; mDataOeRd = 0;
    mAleData = '0; mCmdData = '0; mRdata = '0;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqBe = be; reqWdata = wd;
    busReadyN = (m > 0);
    while (!got && n < 80) begin
      @(negedge clk);
      n++;
      if (busAle) mAle++;
      if (n == 1) begin mAleData = busDataOut; mAleOe = busDataOe; mBheN = busBheN; end
      if (!busRdN || !(&busWrN)) begin
        mCmd++; mCmdData = busDataOut; mCmdOe = busDataOe;
      end
      mLane = mLane | ~busWrN;
      if (!busCsN) mCs++;
      if (!busRdCsN) mRdCs++;
      if (!busWrCsN) mWrCs++;
      if (!busHldaN) mHlda++;
      if (!wr && busDataOe) mDataOeRd = 1;
      busReadyN = (n < m);
      if (reqAck) begin got = 1; mRdata = rspRdata; end
    end
    reqValid = 0;
    mLen = n;
    check(got, "R11 acknowledge seen", got, 1);
  endtask

  task automatic setCfg(input bit mux, input bit ext, input bit dly, input int w,
                        input bit ren, input bit asy);
    cfgMux = mux; cfgExtAle = ext; cfgRwDelay = dly; cfgWait = WAIT_W'(w);
    cfgReadyEn = ren; cfgReadyAsync = asy;
  endtask

  task automatic testReset();
    checkEq("R1 ale", busAle, 0);
    checkEq("R1 rdN", busRdN, 1);
    checkEq("R1 wrN", busWrN, 2'b11);
    checkEq("R1 csN", busCsN, 1);
    checkEq("R1 bheN", busBheN, 1);
    checkEq("R1 hldaN", busHldaN, 1);
    checkEq("R1 breqN", busBreqN, 1);
    checkEq("R1 ack", reqAck, 0);
    checkEq("R1 ctrlOe", busCtrlOe, 1);
  endtask

  task automatic testMuxRead();
    setCfg(1, 0, 0, 0, 0, 0);
    busDataIn = 16'h3C5A;
    doAccess(0, 24'h101234, 2'b11, '0, 0);
    checkEq("R2 mux length", mLen, 6);
    checkEq("R2 ale clocks", mAle, 1);
    checkEq("R2 cmd clocks", mCmd, 3);
    checkEq("R2 address on data", mAleData, 16'h1234);
    checkEq("R2 data oe in ALE", mAleOe, 1);
    checkEq("R9 cs clocks", mCs, 6);
    checkEq("R9 rdcs clocks", mRdCs, 3);
    checkEq("R11 read data", mRdata, 16'h3C5A);
  endtask

  task automatic testDemuxRead();
    setCfg(0, 0, 0, 0, 0, 0);
    busDataIn = 16'h0F1E;
    doAccess(0, 24'h1ABCDE, 2'b11, '0, 0);
    checkEq("R3 demux length", mLen, 4);
    checkEq("R3 cmd clocks", mCmd, 2);
    checkEq("R3 data never driven", mDataOeRd, 0);
    checkEq("R11 read data demux", mRdata, 16'h0F1E);
  endtask

  task automatic testWrites();
    setCfg(0, 0, 0, 0, 0, 0);
    doAccess(1, 24'h100010, 2'b11, 16'hBEEF, 0);
    checkEq("R10 word lanes", mLane, 2'b11);
    checkEq("R10 write data", mCmdData, 16'hBEEF);
    checkEq("R10 write data oe", mCmdOe, 1);
    checkEq("R10 bheN word", mBheN, 0);
    checkEq("R9 wrcs clocks", mWrCs, 2);
    doAccess(1, 24'h100011, 2'b01, 16'h00AA, 0);
    checkEq("R10 low byte lane", mLane, 2'b01);
    checkEq("R10 bheN low byte", mBheN, 1);
    doAccess(1, 24'h100013, 2'b10, 16'h5500, 0);
    checkEq("R10 high byte lane", mLane, 2'b10);
    checkEq("R10 bheN high byte", mBheN, 0);
  endtask

  task automatic testDelay();
    setCfg(1, 0, 1, 0, 0, 0);
    doAccess(0, 24'h100100, 2'b11, '0, 0);
    checkEq("R4 mux length", mLen, expLen(0));
    checkEq("R4 mux cmd clocks", mCmd, 2);
    setCfg(0, 0, 1, 0, 0, 0);
    doAccess(0, 24'h100100, 2'b11, '0, 0);
    checkEq("R4 demux length", mLen, 4);
    checkEq("R4 demux cmd clocks", mCmd, 1);
  endtask

  task automatic testExtAle();
    setCfg(1, 1, 0, 0, 0, 0);
    doAccess(0, 24'h100200, 2'b11, '0, 0);
    checkEq("R5 ale clocks", mAle, 2);
    checkEq("R5 length", mLen, 7);
    checkEq("R5 cmd clocks", mCmd, 3);
  endtask

  task automatic testWaits();
    setCfg(0, 0, 0, 3, 0, 0);
    doAccess(1, 24'h100300, 2'b11, 16'h1357, 0);
    checkEq("R6 length", mLen, 7);
    checkEq("R6 cmd clocks", mCmd, 5);
  endtask

  task automatic testSyncReady();
    setCfg(0, 0, 0, 0, 1, 0);
    doAccess(0, 24'h100400, 2'b11, '0, 5);
    checkEq("R7 sync ready length", mLen, expLen(5));
    checkEq("R7 sync ready length abs", mLen, 6);
    checkEq("R7 sync cmd clocks", mCmd, expCmd(5));
    setCfg(0, 0, 0, 0, 0, 0);
    doAccess(0, 24'h100400, 2'b11, '0, 60);
    checkEq("R7 ready ignored when disabled", mLen, 4);
    busReadyN = 0;
  endtask

  task automatic testAsyncReady();
    setCfg(0, 0, 0, 0, 1, 1);
    repeat (3) @(negedge clk);
    doAccess(0, 24'h100500, 2'b11, '0, 0);
    checkEq("R8 async base length", mLen, 5);
    checkEq("R8 async base cmd", mCmd, 3);
    doAccess(0, 24'h100500, 2'b11, '0, 5);
    checkEq("R8 async stretched length", mLen, expLen(5));
    checkEq("R8 async stretched abs", mLen, 8);
    checkEq("R8 async stretched cmd", mCmd, 6);
  endtask

  task automatic testWindow();
    setCfg(0, 0, 0, 0, 0, 0);
    doAccess(0, 24'h200000, 2'b11, '0, 0);
    checkEq("R9 outside cs", mCs, 0);
    checkEq("R9 outside rdcs", mRdCs, 0);
    checkEq("R9 outside strobe still runs", mCmd, 2);
    doAccess(1, 24'h2FFFFE, 2'b11, 16'h1111, 0);
    checkEq("R9 outside wrcs", mWrCs, 0);
  endtask

  task automatic testHold();
    int n = 0;
    bit got = 0, early = 0;
    setCfg(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = 24'h100600; reqBe = 2'b11;
    busDataIn = 16'h7E81;
    while (!got && n < 40) begin
      @(negedge clk);
      n++;
      if (n == 1) busHoldN = 0;
      if (!busHldaN) early = 1;
      if (reqAck) got = 1;
    end
    reqValid = 0;
    checkEq("R12 cycle completes", n, 4);
    checkEq("R12 no early grant", early, 0);
    @(negedge clk);
    checkEq("R12 still owner in idle clock", busHldaN, 1);
    @(negedge clk);
    checkEq("R12 hold granted", busHldaN, 0);
    checkEq("R12 ctrl oe off", busCtrlOe, 0);
    checkEq("R12 addr oe off", busAddrOe, 0);
    checkEq("R12 data oe off", busDataOe, 0);
    checkEq("R12 cs inactive", busCsN, 1);
    checkEq("R13 no breq without request", busBreqN, 1);
    reqValid = 1; reqAddr = 24'h100602;
    @(negedge clk);
    checkEq("R13 breq raised", busBreqN, 0);
    checkEq("R13 no ALE while released", busAle, 0);
    busHoldN = 1;
    n = 0; got = 0;
    while (!got && n < 40) begin
      @(negedge clk);
      n++;
      if (reqAck) begin got = 1; mRdata = rspRdata; end
    end
    reqValid = 0;
    checkEq("R13 request runs after regain", got, 1);
    checkEq("R13 read data after regain", mRdata, 16'h7E81);
    checkEq("R13 breq cleared", busBreqN, 1);
    checkEq("R13 hlda released", busHldaN, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    repeat (2) @(negedge clk);
    testReset();
    testMuxRead();
    testDemuxRead();
    testWrites();
    testDelay();
    testExtAle();
    testWaits();
    testSyncReady();
    testAsyncReady();
    testWindow();
    testHold();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule